// File: doc/BRIEF.md
# Programmable Bit-Rate Clock Divider

This block turns a fast reference clock into a slow bus-timing strobe. Its output is a one-cycle tick that recurs at the reference rate divided by 4·(4m+1)·2^y. The division runs through three counters in a chain. A fixed divide-by-four prescaler feeds a linear stage that divides by 4m+1. That stage in turn feeds a stage that divides by a power of two. Each counter moves forward only when the counter before it wraps. The tick is the cycle in which all three wrap together.

Settings arrive as a 16-bit timing word and a 3-bit exponent. The timing word carries two timing fields, and in normal use both hold the same value. The upper byte, bits 15:8, is the message timing field, and its value is m. The lower byte, bits 7:0, is the address timing field. The exponent is y. A readback port reports the divisor that is currently applied, so that software can recompute the bus frequency. When the two timing fields disagree, the readback reports zero to mark the setting as invalid.

Software may reprogram the block while it runs. A new value is copied into the applied settings only at a tick boundary, so no tick period is ever cut short. While the enable input is low, every counter stays at zero.

Top module: `bitrate_clkdiv`

## Requirements
- R1: When the two timing fields are equal, the divisor output equals 4·(4m+1)·2^y. The divisor output is 24 bits wide. For m=255, y=7 it reads 522752.
- R2: When the message field (bits 15:8) differs from the address field (bits 7:0), the divisor output is zero.
- R3: While enabled, tick_o is high for exactly one cycle. Consecutive ticks are exactly 4·(4m+1)·2^y reference cycles apart.
- R4: The count length depends only on the message field (bits 15:8) and the exponent. The address field has no effect on the tick spacing.
- R5: A change to the timing word or the exponent while enabled takes effect only after the next tick. Until that tick, both the tick spacing and the divisor output keep their old values.
- R6: While run_en is low, tick_o stays low, the counters are held at zero, and inputs are applied one cycle after they change. After run_en rises, the first tick appears after D−1 clock edges, where D is the divisor.
- R7: During reset, tick_o is low and the divisor output shows the reset setting, m=1 and y=0, which reads 20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Divider enable; low holds all counters at zero |
| timing_word | input | 16 | Bits 15:8 message timing m; bits 7:0 address timing |
| exp_sel | input | 3 | Power-of-two exponent y |
| tick_o | output | 1 | One-cycle bus-timing strobe |
| divisor_o | output | 24 | Applied divisor, or zero when the timing fields differ |

## Verification
The bench builds the block with its default parameters: an 8-bit timing field, a 3-bit exponent and a 24-bit readback. These values place every divisor up to 522752 within reach of the readback check. Full tick periods are measured for divisors up to a few thousand cycles, including the largest m with y=0 and the largest y with a small m. This covers the outer limits of both the linear stage and the power-of-two stage while keeping the run short. Directed cases cover mismatched timing fields, reprogramming in the middle of a period, and holding the divider off and then restarting it.

// File: rtl/bitdiv_pkg.sv
package bitdiv_pkg;

   // Fixed prescale ratio and its counter width
   localparam int unsigned PRE_RATIO = 4;
   localparam int unsigned PRE_W     = 2;

   // Width of the power-of-two stage counter for a given exponent width
   function automatic int unsigned pow_cnt_width(input int unsigned y_w);
      return ((1 << y_w) - 1 > 0) ? (1 << y_w) - 1 : 1;
   endfunction

   // Smallest readback width that can hold the largest divisor
   function automatic int unsigned min_rb_width(input int unsigned m_w, input int unsigned y_w);
      return PRE_W + (m_w + 2) + ((1 << y_w) - 1);
   endfunction

endpackage

// File: rtl/bitdiv_count.sv
module bitdiv_count #(
   parameter int unsigned W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         run_i,
   input  logic         step_i,
   input  logic [W-1:0] lim_i,
   output logic         wrap_o
);

   logic [W-1:0] cnt_q;
   logic         at_lim;

   assign at_lim = (cnt_q == lim_i);
   assign wrap_o = run_i & step_i & at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run_i)
         cnt_q <= '0;
      else if (step_i)
         cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
   end

   // R6
   held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));

   // R5
   within_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q <= lim_i));

   // R3
   wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && step_i && at_lim) |=> (cnt_q == '0));

endmodule

// File: rtl/bitdiv_shadow.sv
module bitdiv_shadow #(
   parameter int unsigned           WW       = 16,
   parameter int unsigned           YW       = 3,
   parameter logic [WW-1:0]         RST_WORD = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [WW-1:0] word_i,
   input  logic [YW-1:0] exp_i,
   output logic [WW-1:0] word_o,
   output logic [YW-1:0] exp_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o <= RST_WORD;
         exp_o  <= '0;
      end else if (load_i) begin
         word_o <= word_i;
         exp_o  <= exp_i;
      end
   end

endmodule

// File: rtl/bitrate_clkdiv.sv
module bitrate_clkdiv #(
   parameter int unsigned M_W   = 8,
   parameter int unsigned Y_W   = 3,
   parameter int unsigned RB_W  = 24,
   parameter int unsigned RST_M = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_en,
   input  logic [2*M_W-1:0]   timing_word,
   input  logic [Y_W-1:0]     exp_sel,
   output logic               tick_o,
   output logic [RB_W-1:0]    divisor_o
);

   import bitdiv_pkg::*;

   localparam int unsigned WW   = 2 * M_W;
   localparam int unsigned LW   = M_W + 2;
   localparam int unsigned PW   = pow_cnt_width(Y_W);
   localparam logic [WW-1:0] RST_WORD = {M_W'(RST_M), M_W'(RST_M)};

   // Elaboration-time parameter checks
   if (M_W < 1)
      $error("bitrate_clkdiv: M_W must be at least 1");
   if (Y_W < 1 || Y_W > 5)
      $error("bitrate_clkdiv: Y_W must lie in 1..5");
   if (RB_W < min_rb_width(M_W, Y_W))
      $error("bitrate_clkdiv: RB_W too narrow for the largest divisor");
   if (RST_M >= (1 << M_W))
      $error("bitrate_clkdiv: RST_M does not fit in M_W bits");

   logic [WW-1:0]  act_word;
   logic [Y_W-1:0] act_exp;
   logic [M_W-1:0] act_msg, act_addr;
   logic           load_set;
   logic           pre_wrap, lin_wrap, pow_wrap;
   logic [LW-1:0]  lin_lim;
   logic [PW-1:0]  pow_lim;

   assign load_set = ~run_en | tick_o;
   assign act_msg  = act_word[WW-1:M_W];
   assign act_addr = act_word[M_W-1:0];

   bitdiv_shadow #(
      .WW       (WW),
      .YW       (Y_W),
      .RST_WORD (RST_WORD)
   ) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load_set),
      .word_i (timing_word),
      .exp_i  (exp_sel),
      .word_o (act_word),
      .exp_o  (act_exp)
   );

   // Stage limits: linear stage wraps after 4m+1 steps, power stage after 2^y
   assign lin_lim = {act_msg, 2'b00};
   assign pow_lim = ~({PW{1'b1}} << act_exp);

   bitdiv_count #(.W(PRE_W)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_en),
      .step_i (1'b1),
      .lim_i  (PRE_W'(PRE_RATIO - 1)),
      .wrap_o (pre_wrap)
   );

   bitdiv_count #(.W(LW)) u_lin (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_en),
      .step_i (pre_wrap),
      .lim_i  (lin_lim),
      .wrap_o (lin_wrap)
   );

   bitdiv_count #(.W(PW)) u_pow (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_en),
      .step_i (lin_wrap),
      .lim_i  (pow_lim),
      .wrap_o (pow_wrap)
   );

   assign tick_o = pow_wrap;

   // Readback of the applied divisor; zero flags disagreeing timing fields
   always_comb begin
      if (act_msg == act_addr)
         divisor_o = (RB_W'(lin_lim) + RB_W'(1)) << (RB_W'(act_exp) + RB_W'(PRE_W));
      else
         divisor_o = '0;
   end

   // R3
   single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

   // R5
   hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !tick_o && $past(run_en) && !$past(tick_o)) |-> $stable(divisor_o));

   // R6
   start_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_en) |-> !tick_o);

   // R6
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |-> !tick_o);

endmodule

// File: tb/bitrate_clkdiv_test.sv
module bitrate_clkdiv_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run_en = 1'b0;
   logic [15:0] timing_word = 16'h0101;
   logic [2:0]  exp_sel = 3'd0;
   logic        tick_o;
   logic [23:0] divisor_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 0;

   always #10 clk = ~clk;   // 50 MHz

   bitrate_clkdiv uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .run_en      (run_en),
      .timing_word (timing_word),
      .exp_sel     (exp_sel),
      .tick_o      (tick_o),
      .divisor_o   (divisor_o)
   );

   // {m, y, expected divisor}
   localparam logic [31:0] VEC [6] = '{
      {8'd1,   3'd0, 21'd20},
      {8'd2,   3'd1, 21'd72},
      {8'd5,   3'd3, 21'd672},
      {8'd17,  3'd2, 21'd1104},
      {8'd255, 3'd0, 21'd4084},
      {8'd2,   3'd7, 21'd4608}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic measure(output int n, input int lim);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!tick_o && n < lim);
   endtask

   function automatic int div_of(input int m, input int y);
      return 4 * (4 * m + 1) * (1 << y);
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 190000 && !done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int n, n2, d;
      repeat (3) @(negedge clk);
      // R7: reset state
      check(tick_o == 1'b0, "R7 tick in reset", tick_o, 0);
      check(divisor_o == 24'd20, "R7 divisor in reset", divisor_o, 20);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table: readback, first tick, period
      foreach (VEC[i]) begin
         int m, y, e;
         m = VEC[i][31:24];
         y = VEC[i][23:21];
         e = VEC[i][20:0];
         timing_word = {8'(m), 8'(m)};
         exp_sel = 3'(y);
         @(negedge clk);
         // R1
         check(divisor_o == 24'(e), "R1 readback", divisor_o, e);
         check(e == div_of(m, y), "R1 table", e, div_of(m, y));
         run_en = 1'b1;
         measure(n, 20000);
         // R6: first tick after D-1 edges
         check(n == e - 1, "R6 first tick", n, e - 1);
         measure(n, 20000);
         // R3: period
         check(n == e, "R3 period", n, e);
         @(negedge clk);
         // R3: single-cycle tick
         check(tick_o == 1'b0, "R3 tick width", tick_o, 0);
         run_en = 1'b0;
         @(negedge clk);
      end

      // R1: largest setting readback
      timing_word = {8'd255, 8'd255};
      exp_sel = 3'd7;
      @(negedge clk);
      check(divisor_o == 24'd522752, "R1 max readback", divisor_o, 522752);

      // R2 / R4: disagreeing fields
      timing_word = {8'd3, 8'd5};
      exp_sel = 3'd0;
      @(negedge clk);
      check(divisor_o == 24'd0, "R2 mismatch readback", divisor_o, 0);
      run_en = 1'b1;
      measure(n, 20000);
      measure(n, 20000);
      check(n == 52, "R4 period from message field", n, 52);
      run_en = 1'b0;
      @(negedge clk);

      // R5: reprogram mid-period
      timing_word = {8'd1, 8'd1};
      exp_sel = 3'd0;
      @(negedge clk);
      run_en = 1'b1;
      measure(n, 20000);
      repeat (5) @(negedge clk);
      timing_word = {8'd3, 8'd3};
      exp_sel = 3'd1;
      @(negedge clk);
      check(divisor_o == 24'd20, "R5 readback held", divisor_o, 20);
      measure(n2, 20000);
      check(6 + n2 == 20, "R5 old period kept", 6 + n2, 20);
      @(negedge clk);
      check(divisor_o == 24'd104, "R5 readback after tick", divisor_o, 104);
      measure(n2, 20000);
      check(1 + n2 == 104, "R5 new period", 1 + n2, 104);

      // R6: disabled, no ticks, restart from zero
      repeat (7) @(negedge clk);
      run_en = 1'b0;
      d = 0;
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         if (tick_o) d++;
      end
      check(d == 0, "R6 no ticks while off", d, 0);
      run_en = 1'b1;
      measure(n, 20000);
      check(n == 103, "R6 restart first tick", n, 103);
      run_en = 1'b0;
      @(negedge clk);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule